// File: doc/BRIEF.md
# Two-Level Local Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Its first level is a direct-mapped, partially tagged history cache. Each entry holds the recent outcomes of one branch in a shift register. Its second level is one table of 2-bit saturating counters that all branches share. The counter is selected by mixing the branch's own history with low bits of its address. A parameter picks how the two are mixed: either the address bits are appended below the history, or the history is XORed with address bits of equal width. Mixing in the address keeps branches that have the same history from disturbing each other's counters.

The fetch side presents an address and reads back, in the same cycle, a hit flag, a taken/not-taken guess and the history that was used. The execute side later returns the same address, the real outcome and that history. On the update strobe, the counter that the history selected moves one step toward the outcome. In the same cycle, the branch's history cache entry is either advanced or newly allocated. Partial tags can alias two branches onto one entry. This costs accuracy only and is tolerated.

Top module: `local_hist_predictor`

## Requirements
- R1: After a synchronous active-low reset, every history cache entry is empty, so any lookup reports `lkp_hit`=0.
- R2: A lookup that misses drives `lkp_hit`=0, `lkp_taken`=0 and `lkp_hist`=0.
- R3: An update whose address misses the history cache allocates the entry for that address with an all-zero history. The outcome being reported is not shifted in.
- R4: An update whose address hits shifts the outcome into bit 0 of the entry's history (1 = taken). Every older bit moves up one place, and bit HIST_W-1 is discarded.
- R5: Every counter leaves reset in the weakly-taken state 2'b10.
- R6: Counter codes are 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. An update adds one on taken and subtracts one on not-taken, holding at 11 and at 00. On a hit, `lkp_taken` is bit 1 of the selected counter.
- R7: In XOR mode, the counter index is the HIST_W-bit history XORed with address bits [PC_LSB+HIST_W-1:PC_LSB].
- R8: In append mode, the counter index is {history, address bits [PC_LSB+CAT_BITS-1:PC_LSB]}, with the history in the upper bits. The table then has 2^(HIST_W+CAT_BITS) counters.
- R9: The cache set is address bits [PC_LSB+IDX_W-1:PC_LSB], and the tag is the next TAG_W bits. A different tag in the same set misses. Updating that different tag replaces the resident entry.
- R10: A lookup that reads the same counter or cache entry that an update writes in the same cycle returns the value from before the update.
- R11: On a hit, `lkp_hist` carries the entry's current history. The update port uses the history it is given to select the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lkp_pc | input | ADDR_W | Branch address looked up at fetch |
| lkp_hit | output | 1 | History cache holds this branch |
| lkp_taken | output | 1 | Predicted direction (1 = taken) |
| lkp_hist | output | HIST_W | History used for this prediction |
| upd_en | input | 1 | Update strobe from execute |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome (1 = taken) |
| upd_hist | input | HIST_W | History returned by the lookup of this branch |

## Verification
A fetch-side lookup and an execute-side update can land in the same cycle, and they can touch the same counter or the same cache entry. The bench provokes this two ways. Every training step looks up a branch and updates it in one cycle. A further step updates a different branch whose mixed index is forced onto the counter that the lookup reads. Each lookup is judged against a bench model whose state has not yet absorbed that cycle's update. Two instances run side by side, one per mixing mode, and each is compared against its own counter model.

// File: rtl/lbp_pkg.sv
// Package: shared constants and helpers of the local-history predictor.
// Assumes: counters are two bits wide; the mixing mode is a two-value enum.
package lbp_pkg;

    typedef enum logic {
        MIX_APPEND = 1'b0,
        MIX_XOR    = 1'b1
    } mix_mode_e;

    localparam logic [1:0] CTR_STRONG_NT = 2'b00;
    localparam logic [1:0] CTR_WEAK_T    = 2'b10;
    localparam logic [1:0] CTR_STRONG_T  = 2'b11;

    // One saturating step of a direction counter toward the outcome.
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        nxt = cur;
        if (taken && cur != CTR_STRONG_T) begin
            nxt = cur + 2'd1;
        end else if (!taken && cur != CTR_STRONG_NT) begin
            nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/lbp_index_mix.sv
// Module: lbp_index_mix
// Builds the counter-table index from a branch address and its history.
// The parameter MIX picks the variant: XOR of history with equally wide
// address bits, or history with CAT_BITS address bits appended below.
// Assumes: CIDX_W matches the chosen variant (HIST_W or HIST_W+CAT_BITS).
module lbp_index_mix #(
    parameter int               ADDR_W   = 32,
    parameter int               HIST_W   = 6,
    parameter int               PC_LSB   = 2,
    parameter int               CAT_BITS = 2,
    parameter lbp_pkg::mix_mode_e MIX    = lbp_pkg::MIX_XOR,
    parameter int               CIDX_W   = HIST_W
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [HIST_W-1:0] hist,
    output logic [CIDX_W-1:0] idx
);
    logic unused_pc_bits;
    assign unused_pc_bits = ^pc;

    generate
        if (MIX == lbp_pkg::MIX_XOR) begin : g_xor
            // Fold the history onto the low address bits.
            always_comb begin
                idx = CIDX_W'(hist ^ pc[PC_LSB +: HIST_W]);
            end
        end else begin : g_append
            // Place the history above the selected address bits.
            always_comb begin
                idx = CIDX_W'({hist, pc[PC_LSB +: CAT_BITS]});
            end
        end
    endgenerate

endmodule

// File: rtl/lbp_hist_cache.sv
// Module: lbp_hist_cache
// Direct-mapped, partially tagged store of per-branch history registers.
// Read is combinational from the registered state; write happens on the
// clock when wr_en is high: a hit shifts the outcome in, a miss allocates
// the set for the new tag with a cleared history.
// Assumes: SETS is a power of two; PC_LSB+IDX_W+TAG_W <= ADDR_W; HIST_W >= 2.
module lbp_hist_cache #(
    parameter int ADDR_W = 32,
    parameter int HIST_W = 6,
    parameter int SETS   = 64,
    parameter int TAG_W  = 8,
    parameter int PC_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_pc,
    output logic              rd_hit,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_pc,
    input  logic              wr_taken
);
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;

    logic              valid_q [SETS];
    logic [TAG_W-1:0]  tag_q   [SETS];
    logic [HIST_W-1:0] hist_q  [SETS];

    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic [TAG_W-1:0]  rd_tag, wr_tag;
    logic              wr_hit;
    logic              unused_pc_bits;

    assign unused_pc_bits = ^{rd_pc, wr_pc};

    // Split both addresses into set index and partial tag.
    always_comb begin
        rd_idx = rd_pc[PC_LSB +: IDX_W];
        rd_tag = rd_pc[PC_LSB + IDX_W +: TAG_W];
        wr_idx = wr_pc[PC_LSB +: IDX_W];
        wr_tag = wr_pc[PC_LSB + IDX_W +: TAG_W];
    end

    // Fetch-side read: hit on valid with matching tag, zero history otherwise.
    always_comb begin
        rd_hit  = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        rd_hist = rd_hit ? hist_q[rd_idx] : '0;
    end

    // Execute-side hit detection for the written set.
    always_comb begin
        wr_hit = valid_q[wr_idx] && (tag_q[wr_idx] == wr_tag);
    end

    // Entry state: clear on reset, shift on hit, allocate on miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                valid_q[i] <= 1'b0;
                tag_q[i]   <= '0;
                hist_q[i]  <= '0;
            end
        end else if (wr_en) begin
            if (wr_hit) begin
                hist_q[wr_idx] <= {hist_q[wr_idx][HIST_W-2:0], wr_taken};
            end else begin
                valid_q[wr_idx] <= 1'b1;
                tag_q[wr_idx]   <= wr_tag;
                hist_q[wr_idx]  <= '0;
            end
        end
    end

    AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> !rd_hit) // R1
        else $error("read hit right after reset");

    AST_ALLOC_ZERO_HIST: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !wr_hit) |=> (valid_q[$past(wr_idx)] && hist_q[$past(wr_idx)] == '0)) // R3
        else $error("allocation did not clear history");

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_hit) |=> hist_q[$past(wr_idx)] == {$past(hist_q[wr_idx][HIST_W-2:0]), $past(wr_taken)}) // R4
        else $error("history did not shift by one");

    AST_REPLACE_TAG: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> tag_q[$past(wr_idx)] == $past(wr_tag)) // R9
        else $error("written set does not hold the written tag");

endmodule

// File: rtl/lbp_counter_table.sv
// Module: lbp_counter_table
// Shared table of 2-bit saturating direction counters, one read port
// (combinational, pre-update value) and one write port (clocked step).
// Assumes: every counter leaves reset weakly taken.
module lbp_counter_table #(
    parameter int CIDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CIDX_W-1:0] rd_idx,
    output logic [1:0]        rd_ctr,
    input  logic              wr_en,
    input  logic [CIDX_W-1:0] wr_idx,
    input  logic              wr_taken
);
    import lbp_pkg::*;

    localparam int ENTRIES = 1 << CIDX_W;

    logic [1:0] ctr_q [ENTRIES];

    // Read the selected counter from the registered state.
    always_comb begin
        rd_ctr = ctr_q[rd_idx];
    end

    // Counter state: weakly taken on reset, one saturating step per update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ctr_q[i] <= CTR_WEAK_T;
            end
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
        end
    end

    AST_CTR_INC: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_taken && ctr_q[wr_idx] != 2'b11) |=> ctr_q[$past(wr_idx)] == $past(ctr_q[wr_idx]) + 2'd1) // R6
        else $error("counter did not increment");

    AST_CTR_DEC: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !wr_taken && ctr_q[wr_idx] != 2'b00) |=> ctr_q[$past(wr_idx)] == $past(ctr_q[wr_idx]) - 2'd1) // R6
        else $error("counter did not decrement");

    AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_taken && ctr_q[wr_idx] == 2'b11) |=> ctr_q[$past(wr_idx)] == 2'b11) // R6
        else $error("counter wrapped above strong taken");

    AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !wr_taken && ctr_q[wr_idx] == 2'b00) |=> ctr_q[$past(wr_idx)] == 2'b00) // R6
        else $error("counter wrapped below strong not-taken");

    AST_RESET_WEAK_T: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> rd_ctr == 2'b10) // R5
        else $error("counter not weakly taken after reset");

endmodule

// File: rtl/local_hist_predictor.sv
// Module: local_hist_predictor (top)
// Two-level local direction predictor: a tagged per-branch history cache
// feeds a shared saturating-counter table through an index mixer.
// Lookup is combinational and sees state before any same-cycle update.
// Update steps the counter chosen by the supplied history and advances
// or allocates the history entry, all on one clock edge.
// Assumes: upd_hist is the history the lookup of that branch returned.
module local_hist_predictor #(
    parameter int                 ADDR_W   = 32,
    parameter int                 HIST_W   = 6,
    parameter int                 SETS     = 64,
    parameter int                 TAG_W    = 8,
    parameter int                 PC_LSB   = 2,
    parameter int                 CAT_BITS = 2,
    parameter lbp_pkg::mix_mode_e MIX      = lbp_pkg::MIX_XOR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lkp_pc,
    output logic              lkp_hit,
    output logic              lkp_taken,
    output logic [HIST_W-1:0] lkp_hist,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [HIST_W-1:0] upd_hist
);
    localparam int CIDX_W = (MIX == lbp_pkg::MIX_XOR) ? HIST_W : HIST_W + CAT_BITS;

    logic              rd_hit;
    logic [HIST_W-1:0] rd_hist;
    logic [CIDX_W-1:0] rd_cidx, wr_cidx;
    logic [1:0]        rd_ctr;

    lbp_hist_cache #(
        .ADDR_W (ADDR_W),
        .HIST_W (HIST_W),
        .SETS   (SETS),
        .TAG_W  (TAG_W),
        .PC_LSB (PC_LSB)
    ) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_pc    (lkp_pc),
        .rd_hit   (rd_hit),
        .rd_hist  (rd_hist),
        .wr_en    (upd_en),
        .wr_pc    (upd_pc),
        .wr_taken (upd_taken)
    );

    lbp_index_mix #(
        .ADDR_W   (ADDR_W),
        .HIST_W   (HIST_W),
        .PC_LSB   (PC_LSB),
        .CAT_BITS (CAT_BITS),
        .MIX      (MIX),
        .CIDX_W   (CIDX_W)
    ) u_mix_rd (
        .pc   (lkp_pc),
        .hist (rd_hist),
        .idx  (rd_cidx)
    );

    lbp_index_mix #(
        .ADDR_W   (ADDR_W),
        .HIST_W   (HIST_W),
        .PC_LSB   (PC_LSB),
        .CAT_BITS (CAT_BITS),
        .MIX      (MIX),
        .CIDX_W   (CIDX_W)
    ) u_mix_wr (
        .pc   (upd_pc),
        .hist (upd_hist),
        .idx  (wr_cidx)
    );

    lbp_counter_table #(
        .CIDX_W (CIDX_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_cidx),
        .rd_ctr   (rd_ctr),
        .wr_en    (upd_en),
        .wr_idx   (wr_cidx),
        .wr_taken (upd_taken)
    );

    // Prediction: counter MSB on a hit, not-taken on a miss.
    always_comb begin
        lkp_hit   = rd_hit;
        lkp_taken = rd_hit && rd_ctr[1];
        lkp_hist  = rd_hist;
    end

    AST_MISS_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) !lkp_hit |-> (!lkp_taken && lkp_hist == '0)) // R2
        else $error("miss produced a taken guess or a history");

endmodule

// File: tb/local_hist_predictor_tb.sv
`timescale 1ns/1ps
module local_hist_predictor_tb;
    localparam int HW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lkp_pc = '0;
    logic        upd_en = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [HW-1:0] upd_hist = '0;

    logic          hit_x, tk_x, hit_c, tk_c;
    logic [HW-1:0] hist_x, hist_c;

    always #2 clk = ~clk;

    local_hist_predictor #(.MIX(lbp_pkg::MIX_XOR)) u_dut (
        .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_hit(hit_x),
        .lkp_taken(tk_x), .lkp_hist(hist_x), .upd_en(upd_en), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_hist(upd_hist));

    local_hist_predictor #(.MIX(lbp_pkg::MIX_APPEND)) u_dut_cat (
        .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_hit(hit_c),
        .lkp_taken(tk_c), .lkp_hist(hist_c), .upd_en(upd_en), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_hist(upd_hist));

    // Reference state built from the requirements.
    bit          m_val  [64];
    logic [7:0]  m_tag  [64];
    logic [HW-1:0] m_hist [64];
    logic [1:0]  m_cx   [64];
    logic [1:0]  m_cc   [256];

    typedef struct packed {
        logic          hit;
        logic          tkx;
        logic          tkc;
        logic [HW-1:0] hist;
    } exp_t;

    exp_t  exp_q [$];
    string req_q [$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    function automatic logic [5:0] set_of(logic [31:0] pc);  return pc[7:2];  endfunction
    function automatic logic [7:0] tag_of(logic [31:0] pc);  return pc[15:8]; endfunction
    function automatic logic [5:0] ix_x(logic [31:0] pc, logic [HW-1:0] h); return h ^ pc[7:2]; endfunction
    function automatic logic [7:0] ix_c(logic [31:0] pc, logic [HW-1:0] h); return {h, pc[3:2]}; endfunction

    function automatic bit m_hit(logic [31:0] pc);
        return m_val[set_of(pc)] && m_tag[set_of(pc)] == tag_of(pc);
    endfunction

    function automatic logic [HW-1:0] m_h(logic [31:0] pc);
        return m_hit(pc) ? m_hist[set_of(pc)] : '0;
    endfunction

    function automatic logic [1:0] step(logic [1:0] c, bit t);
        if (t)  return (c == 2'b11) ? c : c + 2'd1;
        return (c == 2'b00) ? c : c - 2'd1;
    endfunction

    task automatic m_update(logic [31:0] pc, bit t, logic [HW-1:0] h);
        m_cx[ix_x(pc, h)] = step(m_cx[ix_x(pc, h)], t);
        m_cc[ix_c(pc, h)] = step(m_cc[ix_c(pc, h)], t);
        if (m_hit(pc)) begin
            m_hist[set_of(pc)] = {m_hist[set_of(pc)][HW-2:0], t};
        end else begin
            m_val[set_of(pc)]  = 1'b1;
            m_tag[set_of(pc)]  = tag_of(pc);
            m_hist[set_of(pc)] = '0;
        end
    endtask

    // Driver: one cycle of optional lookup and optional update; expectations
    // come from the model before that cycle's update is applied (R10).
    task automatic drive(bit dl, logic [31:0] lpc, bit du, logic [31:0] upc,
                         bit ut, logic [HW-1:0] uh, string req);
        exp_t e;
        @(posedge clk); #1;
        lkp_pc = lpc; upd_en = du; upd_pc = upc; upd_taken = ut; upd_hist = uh;
        if (dl) begin
            e.hit  = m_hit(lpc);
            e.hist = m_h(lpc);
            e.tkx  = e.hit && m_cx[ix_x(lpc, e.hist)][1];
            e.tkc  = e.hit && m_cc[ix_c(lpc, e.hist)][1];
            exp_q.push_back(e);
            req_q.push_back(req);
        end
        if (du) m_update(upc, ut, uh);
    endtask

    task automatic look(logic [31:0] pc, string req);
        drive(1, pc, 0, '0, 0, '0, req);
    endtask

    task automatic train(logic [31:0] pc, bit t, string req);
        drive(1, pc, 1, pc, t, m_h(pc), req);
    endtask

    // Monitor: compare both instances against the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t  e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                checks++;
                if ({hit_x, tk_x, hist_x} !== {e.hit, e.tkx, e.hist}) begin
                    errors++;
                    $display("FAIL %s xor-mode {hit,taken,hist} got %b_%b_%h exp %b_%b_%h",
                             r, hit_x, tk_x, hist_x, e.hit, e.tkx, e.hist);
                end
                checks++;
                if ({hit_c, tk_c, hist_c} !== {e.hit, e.tkc, e.hist}) begin
                    errors++;
                    $display("FAIL %s append-mode {hit,taken,hist} got %b_%b_%h exp %b_%b_%h",
                             r, hit_c, tk_c, hist_c, e.hit, e.tkc, e.hist);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired (all requirements)");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] pc_a, pc_b, pc_c, pc_d, pc_g, pc_x;
        logic [HW-1:0] h_a;
        logic [15:0] lfsr;
        for (int i = 0; i < 64; i++) begin
            m_val[i] = 0; m_tag[i] = '0; m_hist[i] = '0; m_cx[i] = 2'b10;
        end
        for (int i = 0; i < 256; i++) m_cc[i] = 2'b10;
        pc_a = 32'h0000_1010;
        pc_b = 32'h0000_2010;
        pc_c = 32'h0000_1024;
        pc_d = 32'h0000_3040;
        pc_g = 32'h0000_4088;
        pc_x = 32'h0000_50C8;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        look(pc_a, "R1 reset lookup misses");
        train(pc_a, 1, "R2 miss gives not-taken");
        look(pc_a, "R3 allocated with zero history");

        // Counter at history 0 of pc_c untouched: weakly taken predicts taken.
        drive(0, '0, 1, pc_c, 0, 6'h15, "R3");
        look(pc_c, "R5 untouched counter is weakly taken");

        train(pc_a, 1, "R4 shift in taken");
        train(pc_a, 1, "R4 shift in taken");
        train(pc_a, 0, "R4 shift in not-taken");
        look(pc_a, "R4/R11 history after shifts");
        for (int i = 0; i < 7; i++) train(pc_a, 1, "R4 oldest bits drop out");
        look(pc_a, "R4/R11 history all ones");

        for (int i = 0; i < 10; i++) train(pc_d, 1, "R6 saturate toward strong taken");
        for (int i = 0; i < 12; i++) train(pc_d, 0, "R6 saturate toward strong not-taken");
        look(pc_d, "R6 prediction is counter msb");

        train(pc_b, 0, "R9 same set other tag misses");
        look(pc_a, "R9 resident entry was replaced");
        look(pc_b, "R9 new tag now hits");

        // Same-cycle: update of another branch lands on the counter pc_g reads.
        train(pc_g, 1, "R10 allocate");
        train(pc_g, 0, "R10 lookup and update same entry");
        h_a = m_h(pc_g) ^ pc_g[7:2] ^ pc_x[7:2];
        for (int i = 0; i < 3; i++)
            drive(1, pc_g, 1, pc_x, 0, h_a, "R10 lookup sees pre-update counter");
        look(pc_g, "R10 counter after the colliding updates");

        // Mixed traffic over several branches exercising both index variants.
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            logic [31:0] pc;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pc = {16'h0, 4'h6, 2'b00, lfsr[1:0], 2'b00, lfsr[3:2], lfsr[4], 3'b000};
            if (lfsr[6:5] == 2'b11) look(pc, "R7/R8 mixed lookup");
            else train(pc, (lfsr[9:7] != 3'b000) ^ lfsr[4], "R7/R8 mixed pattern");
        end

        drive(0, '0, 0, '0, 0, '0, "idle");
        repeat (3) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule